// File: doc/BRIEF.md
# Single-Channel Bus-Bridging DMA Engine

This block copies data between an on-chip memory bus and a memory port that faces a PCI Express controller. Software programs a 64-bit PCIe-side address, a 32-bit internal address and a byte count through a 32-bit register interface. It picks a direction and sets both a global enable and a channel enable. The engine then moves the data in 8-byte beats. Each beat is one read on the source port followed by one write on the destination port.

The remaining byte count, the advancing addresses and a set of sticky status flags can be read back at any time. Software takes a transfer as successful when the transfer-end flag is set and the count reads zero. One interrupt line is raised by any status flag whose enable bit is set. Clearing the channel enable halts a running transfer. An error response on either port halts it too.

Top module: `xdma_bridge`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither memory port requests.
- R2: A transfer starts only while the global enable (bit 31 at 0x4000) and the channel enable (bit 31 of control, 0x4128) are both 1. The active flag is bit 16 at 0x4000 and reads 1 only while the engine is busy.
- R3: Control bit 30 set to 1 reads from the internal port at the internal address (0x4108) and writes to the PCIe port. Bit 30 set to 0 does the reverse. The PCIe address, with low word at 0x4100 and high word at 0x4104, always addresses the PCIe port.
- R4: Each beat is one source read, then one destination write of the data that was read, with one request outstanding at most. A completed beat adds 8 to both addresses and takes 8 from the count at 0x4110. The carry from the PCIe low word passes into the high word.
- R5: When the count reaches zero, transfer end (status bit 0, register 0x412C) sets. The active flag clears and the engine clears the channel enable itself.
- R6: A start with a count that is not a multiple of 8, or that is above 0x7FFFFFF, sets termination (status bit 12) and moves no data.
- R7: An error response stops the transfer. An internal-port error sets status bit 9 and a PCIe-port error sets bit 11. The count keeps the bytes that were not moved.
- R8: Clearing the channel enable while busy stops the transfer. No request follows, and the count and addresses stay readable and consistent.
- R9: Status flags (bits 0, 9, 11, 12) are write-1-to-clear. Enable bits (3, 25, 27, 28) are plain read/write.
- R10: `irq` is high, one cycle after the flag changes, exactly when a flag is set together with its enable. The pairs are bit 0 with bit 3, bit 9 with 25, bit 11 with 27 and bit 12 with 28.
- R11: While active, writes to the address and count registers, and to the direction bit, are ignored.
- R12: A start with a count of zero sets transfer end at once and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt |
| int_req | output | 1 | Internal port request |
| int_we | output | 1 | Internal port write (1) / read (0) |
| int_addr | output | 32 | Internal port address |
| int_wdata | output | 64 | Internal port write data |
| int_ready | input | 1 | Internal port accepts request |
| int_rvalid | input | 1 | Internal port response valid |
| int_rdata | input | 64 | Internal port read data |
| int_err | input | 1 | Internal port error response |
| pcie_req | output | 1 | PCIe port request |
| pcie_we | output | 1 | PCIe port write (1) / read (0) |
| pcie_addr | output | 64 | PCIe port address |
| pcie_wdata | output | 64 | PCIe port write data |
| pcie_ready | input | 1 | PCIe port accepts request |
| pcie_rvalid | input | 1 | PCIe port response valid |
| pcie_rdata | input | 64 | PCIe port read data |
| pcie_err | input | 1 | PCIe port error response |

## Verification
Some properties are checked on every cycle. The two ports never request together. A start happens only under both enables and with a legal count. The engine leaves its busy state only once the start condition is gone. The count holds between beats, and the interrupt follows the enabled flags. Other behaviour only the bench's directed scenarios can show. This covers the data and address pattern on the destination port in both directions, and the carry into the high PCIe word. It also covers the remaining count after an error on a given beat, write-1-to-clear, and writes being ignored while active.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
   // register offsets
   localparam logic [15:0] OFS_GLOBAL = 16'h4000;
   localparam logic [15:0] OFS_PAL    = 16'h4100;
   localparam logic [15:0] OFS_PAH    = 16'h4104;
   localparam logic [15:0] OFS_IA     = 16'h4108;
   localparam logic [15:0] OFS_CNT    = 16'h4110;
   localparam logic [15:0] OFS_CTRL   = 16'h4128;
   localparam logic [15:0] OFS_STAT   = 16'h412C;
   // bit positions
   localparam int B_GEN    = 31;
   localparam int B_ACT    = 16;
   localparam int B_CEN    = 31;
   localparam int B_DIR    = 30;
   localparam int B_TE     = 0;
   localparam int B_TE_EN  = 3;
   localparam int B_IBE    = 9;
   localparam int B_PEE    = 11;
   localparam int B_TRM    = 12;
   localparam int B_IBE_EN = 25;
   localparam int B_PEE_EN = 27;
   localparam int B_TRM_EN = 28;

   typedef enum logic [2:0] {MV_IDLE, MV_RD, MV_RDW, MV_WR, MV_WRW} mv_state_t;

   typedef struct packed {
      logic done;
      logic term;
      logic ierr;
      logic perr;
      logic step;
   } mv_evt_t;
endpackage

// File: rtl/xdma_mover.sv
module xdma_mover
   import xdma_pkg::*;
#(
   parameter int BEAT_BYTES = 8,
   localparam int DW = BEAT_BYTES * 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          dir,
   input  logic [31:0]   cnt,
   input  logic          cnt_ok,
   input  logic [63:0]   pa,
   input  logic [31:0]   ia,
   output logic          busy,
   output mv_evt_t       evt,
   output logic          int_req,
   output logic          int_we,
   output logic [31:0]   int_addr,
   output logic [DW-1:0] int_wdata,
   input  logic          int_ready,
   input  logic          int_rvalid,
   input  logic [DW-1:0] int_rdata,
   input  logic          int_err,
   output logic          pcie_req,
   output logic          pcie_we,
   output logic [63:0]   pcie_addr,
   output logic [DW-1:0] pcie_wdata,
   input  logic          pcie_ready,
   input  logic          pcie_rvalid,
   input  logic [DW-1:0] pcie_rdata,
   input  logic          pcie_err
);
   localparam logic [31:0] STEP32 = 32'(BEAT_BYTES);

   mv_state_t     st;
   logic [DW-1:0] hold_q;

   // dir=1: internal is source, PCIe is destination
   logic          src_rdy, src_rv, src_err, dst_rdy, dst_rv, dst_err;
   logic [DW-1:0] src_data;
   logic          last_beat, rd_ph, wr_ph;

   assign src_rdy   = dir ? int_ready  : pcie_ready;
   assign src_rv    = dir ? int_rvalid : pcie_rvalid;
   assign src_err   = dir ? int_err    : pcie_err;
   assign src_data  = dir ? int_rdata  : pcie_rdata;
   assign dst_rdy   = dir ? pcie_ready  : int_ready;
   assign dst_rv    = dir ? pcie_rvalid : int_rvalid;
   assign dst_err   = dir ? pcie_err    : int_err;
   assign last_beat = (cnt == STEP32);
   assign rd_ph     = go && (st == MV_RD);
   assign wr_ph     = go && (st == MV_WR);

   assign busy       = (st != MV_IDLE);
   assign int_req    = (rd_ph && dir) || (wr_ph && !dir);
   assign pcie_req   = (rd_ph && !dir) || (wr_ph && dir);
   assign int_we     = (st == MV_WR);
   assign pcie_we    = (st == MV_WR);
   assign int_addr   = ia;
   assign pcie_addr  = pa;
   assign int_wdata  = hold_q;
   assign pcie_wdata = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= MV_IDLE;
         hold_q <= '0;
      end else if (st != MV_IDLE && !go) begin
         st <= MV_IDLE;
      end else begin
         unique case (st)
            MV_IDLE: if (go && cnt_ok && cnt != '0) st <= MV_RD;
            MV_RD:   if (src_rdy) st <= MV_RDW;
            MV_RDW:  if (src_rv) begin
                        if (src_err) st <= MV_IDLE;
                        else begin
                           hold_q <= src_data;
                           st     <= MV_WR;
                        end
                     end
            MV_WR:   if (dst_rdy) st <= MV_WRW;
            MV_WRW:  if (dst_rv) st <= (dst_err || last_beat) ? MV_IDLE : MV_RD;
            default: st <= MV_IDLE;
         endcase
      end
   end

   always_comb begin
      evt = '0;
      if (go) begin
         unique case (st)
            MV_IDLE: begin
               if (!cnt_ok)        evt.term = 1'b1;
               else if (cnt == '0) evt.done = 1'b1;
            end
            MV_RDW: if (src_rv && src_err) begin
               evt.ierr = dir;
               evt.perr = !dir;
            end
            MV_WRW: if (dst_rv) begin
               if (dst_err) begin
                  evt.perr = dir;
                  evt.ierr = !dir;
               end else begin
                  evt.step = 1'b1;
                  evt.done = last_beat;
               end
            end
            default: evt = '0;
         endcase
      end
   end
endmodule

// File: rtl/xdma_regs.sv
module xdma_regs
   import xdma_pkg::*;
#(
   parameter int          BEAT_BYTES = 8,
   parameter logic [31:0] CNT_MAX    = 32'h07FF_FFFF,
   parameter bit          IRQ_REG    = 1'b1,
   parameter int          REG_AW     = 16,
   localparam int         LOG_B      = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  mv_evt_t           evt,
   output logic              g_en,
   output logic              c_en,
   output logic              go,
   output logic              dir,
   output logic [31:0]       cnt,
   output logic              cnt_ok,
   output logic [63:0]       pa,
   output logic [31:0]       ia,
   output logic              irq
);
   localparam logic [63:0] STEP64 = 64'(BEAT_BYTES);
   localparam logic [31:0] STEP32 = 32'(BEAT_BYTES);

   if (BEAT_BYTES < 2 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_beat
      $error("BEAT_BYTES must be a power of two of at least 2");
   end
   if (REG_AW < 15) begin : g_bad_aw
      $error("REG_AW too narrow for the register map");
   end

   logic        f_te, f_ibe, f_pee, f_trm;
   logic        e_te, e_ibe, e_pee, e_trm;
   logic        w_gl, w_pal, w_pah, w_ia, w_cnt, w_ctl, w_st;
   logic        stop_ev;
   logic        irq_raw;

   assign w_gl  = reg_we && reg_addr == REG_AW'(OFS_GLOBAL);
   assign w_pal = reg_we && reg_addr == REG_AW'(OFS_PAL) && !busy;
   assign w_pah = reg_we && reg_addr == REG_AW'(OFS_PAH) && !busy;
   assign w_ia  = reg_we && reg_addr == REG_AW'(OFS_IA)  && !busy;
   assign w_cnt = reg_we && reg_addr == REG_AW'(OFS_CNT) && !busy;
   assign w_ctl = reg_we && reg_addr == REG_AW'(OFS_CTRL);
   assign w_st  = reg_we && reg_addr == REG_AW'(OFS_STAT);

   assign stop_ev = evt.done || evt.term || evt.ierr || evt.perr;
   assign go      = g_en && c_en;
   assign cnt_ok  = (cnt <= CNT_MAX) && (cnt[LOG_B-1:0] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g_en <= 1'b0;
         c_en <= 1'b0;
         dir  <= 1'b0;
         pa   <= '0;
         ia   <= '0;
         cnt  <= '0;
         {f_te, f_ibe, f_pee, f_trm} <= '0;
         {e_te, e_ibe, e_pee, e_trm} <= '0;
      end else begin
         if (w_gl)  g_en <= reg_wdata[B_GEN];
         if (w_pal) pa[31:0]  <= reg_wdata;
         if (w_pah) pa[63:32] <= reg_wdata;
         if (w_ia)  ia  <= reg_wdata;
         if (w_cnt) cnt <= reg_wdata;
         if (evt.step) begin
            pa  <= pa + STEP64;
            ia  <= ia + STEP32;
            cnt <= cnt - STEP32;
         end
         if (w_ctl) begin
            c_en <= reg_wdata[B_CEN];
            if (!busy) dir <= reg_wdata[B_DIR];
         end
         if (stop_ev) c_en <= 1'b0;
         if (w_st) begin
            e_te  <= reg_wdata[B_TE_EN];
            e_ibe <= reg_wdata[B_IBE_EN];
            e_pee <= reg_wdata[B_PEE_EN];
            e_trm <= reg_wdata[B_TRM_EN];
         end
         f_te  <= (f_te  && !(w_st && reg_wdata[B_TE]))  || evt.done;
         f_ibe <= (f_ibe && !(w_st && reg_wdata[B_IBE])) || evt.ierr;
         f_pee <= (f_pee && !(w_st && reg_wdata[B_PEE])) || evt.perr;
         f_trm <= (f_trm && !(w_st && reg_wdata[B_TRM])) || evt.term;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_AW'(OFS_GLOBAL): begin
            reg_rdata[B_GEN] = g_en;
            reg_rdata[B_ACT] = busy;
         end
         REG_AW'(OFS_PAL):  reg_rdata = pa[31:0];
         REG_AW'(OFS_PAH):  reg_rdata = pa[63:32];
         REG_AW'(OFS_IA):   reg_rdata = ia;
         REG_AW'(OFS_CNT):  reg_rdata = cnt;
         REG_AW'(OFS_CTRL): begin
            reg_rdata[B_CEN] = c_en;
            reg_rdata[B_DIR] = dir;
         end
         REG_AW'(OFS_STAT): begin
            reg_rdata[B_TE]     = f_te;
            reg_rdata[B_IBE]    = f_ibe;
            reg_rdata[B_PEE]    = f_pee;
            reg_rdata[B_TRM]    = f_trm;
            reg_rdata[B_TE_EN]  = e_te;
            reg_rdata[B_IBE_EN] = e_ibe;
            reg_rdata[B_PEE_EN] = e_pee;
            reg_rdata[B_TRM_EN] = e_trm;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign irq_raw = (f_te && e_te) || (f_ibe && e_ibe) || (f_pee && e_pee) || (f_trm && e_trm);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;

      // R10
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_raw |=> irq);
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   // R11
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !evt.step) |=> $stable(cnt));
endmodule

// File: rtl/xdma_bridge.sv
module xdma_bridge
   import xdma_pkg::*;
#(
   parameter int          BEAT_BYTES = 8,
   parameter logic [31:0] CNT_MAX    = 32'h07FF_FFFF,
   parameter bit          IRQ_REG    = 1'b1,
   parameter int          REG_AW     = 16,
   localparam int         DW         = BEAT_BYTES * 8,
   localparam int         LOG_B      = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              int_req,
   output logic              int_we,
   output logic [31:0]       int_addr,
   output logic [DW-1:0]     int_wdata,
   input  logic              int_ready,
   input  logic              int_rvalid,
   input  logic [DW-1:0]     int_rdata,
   input  logic              int_err,
   output logic              pcie_req,
   output logic              pcie_we,
   output logic [63:0]       pcie_addr,
   output logic [DW-1:0]     pcie_wdata,
   input  logic              pcie_ready,
   input  logic              pcie_rvalid,
   input  logic [DW-1:0]     pcie_rdata,
   input  logic              pcie_err
);
   logic        busy, g_en, c_en, go, dir, cnt_ok;
   logic [31:0] cnt, ia;
   logic [63:0] pa;
   mv_evt_t     evt;

   xdma_regs #(
      .BEAT_BYTES(BEAT_BYTES), .CNT_MAX(CNT_MAX), .IRQ_REG(IRQ_REG), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .evt(evt),
      .g_en(g_en), .c_en(c_en), .go(go), .dir(dir), .cnt(cnt), .cnt_ok(cnt_ok),
      .pa(pa), .ia(ia), .irq(irq)
   );

   xdma_mover #(.BEAT_BYTES(BEAT_BYTES)) u_mover (
      .clk(clk), .rst_n(rst_n), .go(go), .dir(dir), .cnt(cnt), .cnt_ok(cnt_ok),
      .pa(pa), .ia(ia), .busy(busy), .evt(evt),
      .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
      .int_ready(int_ready), .int_rvalid(int_rvalid), .int_rdata(int_rdata), .int_err(int_err),
      .pcie_req(pcie_req), .pcie_we(pcie_we), .pcie_addr(pcie_addr), .pcie_wdata(pcie_wdata),
      .pcie_ready(pcie_ready), .pcie_rvalid(pcie_rvalid), .pcie_rdata(pcie_rdata), .pcie_err(pcie_err)
   );

   // R4
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_req && pcie_req));

   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(g_en && c_en));

   // R6
   legal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cnt) <= CNT_MAX && $past(cnt[LOG_B-1:0]) == '0));

   // R5
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !(g_en && c_en));
endmodule

// File: tb/sim_xdma_bridge.sv
module sim_xdma_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        int_req, int_we, pcie_req, pcie_we;
   logic [31:0] int_addr;
   logic [63:0] pcie_addr, int_wdata, pcie_wdata;
   logic        int_ready = 1'b1, pcie_ready = 1'b1;
   logic        int_rvalid = 1'b0, pcie_rvalid = 1'b0;
   logic        int_err = 1'b0, pcie_err = 1'b0;
   logic [63:0] int_rdata = '0, pcie_rdata = '0;

   always #4 clk = ~clk;

   xdma_bridge u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
      .int_ready(int_ready), .int_rvalid(int_rvalid), .int_rdata(int_rdata), .int_err(int_err),
      .pcie_req(pcie_req), .pcie_we(pcie_we), .pcie_addr(pcie_addr), .pcie_wdata(pcie_wdata),
      .pcie_ready(pcie_ready), .pcie_rvalid(pcie_rvalid), .pcie_rdata(pcie_rdata), .pcie_err(pcie_err)
   );

   int n_chk = 0, n_bad = 0, n_int = 0, n_pcie = 0, n_log = 0;
   bit done_flag = 0;
   logic [63:0] log_addr [64];
   logic [63:0] log_data [64];
   logic        log_pcie [64];
   logic        ierr_arm = 0, perr_arm = 0;
   logic [63:0] ierr_addr = '0, perr_addr = '0;

   function automatic logic [63:0] pat(input logic [63:0] a);
      return {a[31:0] ^ 32'h5A5A_5A5A, a[63:32] + a[31:0]};
   endfunction

   // memory responders: accept on ready, answer one cycle later
   logic        ip_pend = 0, pp_pend = 0, ip_we, pp_we;
   logic [63:0] ip_addr, pp_addr, ip_wd, pp_wd;
   always @(negedge clk) begin
      int_rvalid = 1'b0; int_err = 1'b0;
      pcie_rvalid = 1'b0; pcie_err = 1'b0;
      if (ip_pend) begin
         int_rvalid = 1'b1;
         int_err    = ierr_arm && ip_addr == ierr_addr;
         int_rdata  = pat(ip_addr);
         if (ip_we && !int_err && n_log < 64) begin
            log_addr[n_log] = ip_addr; log_data[n_log] = ip_wd; log_pcie[n_log] = 1'b0;
            n_log++;
         end
         ip_pend = 1'b0;
      end
      if (pp_pend) begin
         pcie_rvalid = 1'b1;
         pcie_err    = perr_arm && pp_addr == perr_addr;
         pcie_rdata  = pat(pp_addr);
         if (pp_we && !pcie_err && n_log < 64) begin
            log_addr[n_log] = pp_addr; log_data[n_log] = pp_wd; log_pcie[n_log] = 1'b1;
            n_log++;
         end
         pp_pend = 1'b0;
      end
      if (rst_n && int_req && int_ready) begin
         ip_pend = 1'b1; ip_we = int_we; ip_addr = {32'h0, int_addr}; ip_wd = int_wdata; n_int++;
      end
      if (rst_n && pcie_req && pcie_ready) begin
         pp_pend = 1'b1; pp_we = pcie_we; pp_addr = pcie_addr; pp_wd = pcie_wdata; n_pcie++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle_wait;
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(16'h4000, v);
         if (!v[16]) return;
      end
   endtask

   task automatic clear_log;
      n_log = 0; n_int = 0; n_pcie = 0;
   endtask

   task automatic launch(input logic [63:0] pa, input logic [31:0] ia,
                         input logic [31:0] cnt, input logic dir);
      wr(16'h4100, pa[31:0]);
      wr(16'h4104, pa[63:32]);
      wr(16'h4108, ia);
      wr(16'h4110, cnt);
      wr(16'h412C, 32'h0000_1A01);
      clear_log();
      wr(16'h4000, 32'h8000_0000);
      wr(16'h4128, {1'b1, dir, 30'h0});
   endtask

   task automatic t_reset;
      logic [31:0] v;
      logic [15:0] offs [7] = '{16'h4000, 16'h4100, 16'h4104, 16'h4108, 16'h4110, 16'h4128, 16'h412C};
      for (int i = 0; i < 7; i++) begin
         rd(offs[i], v);
         chk("R1 register reset value", v, 0);
      end
      chk("R1 irq at reset", irq, 0);
      chk("R1 no request at reset", n_int + n_pcie, 0);
   endtask

   task automatic t_gate;
      logic [31:0] v;
      wr(16'h4110, 32'd16);
      clear_log();
      wr(16'h4128, 32'h8000_0000);
      repeat (10) @(negedge clk);
      rd(16'h4000, v);
      chk("R2 channel enable alone: active", v[16], 0);
      chk("R2 channel enable alone: requests", n_int + n_pcie, 0);
      wr(16'h4128, 32'h0);
      wr(16'h4000, 32'h8000_0000);
      repeat (10) @(negedge clk);
      rd(16'h4000, v);
      chk("R2 global enable alone: active", v[16], 0);
      chk("R2 global enable alone: requests", n_int + n_pcie, 0);
      wr(16'h4000, 32'h0);
   endtask

   task automatic t_int_to_pcie;
      logic [31:0] v;
      logic [63:0] pa0 = 64'h0000_0001_FFFF_FFF0;
      logic [31:0] ia0 = 32'h0000_2000;
      launch(pa0, ia0, 32'd32, 1'b1);
      rd(16'h4000, v);
      chk("R2 active while running", v[16], 1);
      idle_wait();
      chk("R4 four PCIe writes", n_log, 4);
      chk("R4 reads and writes issued", {n_int[31:0], n_pcie[31:0]}, {32'd4, 32'd4});
      for (int i = 0; i < 4 && i < n_log; i++) begin
         chk("R3 write on PCIe port", log_pcie[i], 1);
         chk("R3 PCIe write address", log_addr[i], pa0 + 64'(8 * i));
         chk("R4 data from internal read", log_data[i], pat({32'h0, ia0 + 32'(8 * i)}));
      end
      rd(16'h4110, v); chk("R5 count zero", v, 0);
      rd(16'h412C, v); chk("R5 transfer end set", v[0], 1);
      rd(16'h4128, v); chk("R5 channel enable self-cleared", v[31], 0);
      rd(16'h4000, v); chk("R5 active cleared", v[16], 0);
      rd(16'h4104, v); chk("R4 carry into PCIe high", v, 32'h2);
      rd(16'h4100, v); chk("R4 PCIe low advanced", v, 32'h10);
      rd(16'h4108, v); chk("R4 internal address advanced", v, ia0 + 32);
   endtask

   task automatic t_pcie_to_int;
      logic [31:0] v;
      logic [63:0] pa0 = 64'h0000_0030_8000_0100;
      logic [31:0] ia0 = 32'h0004_0000;
      launch(pa0, ia0, 32'd24, 1'b0);
      idle_wait();
      chk("R3 three internal writes", n_log, 3);
      for (int i = 0; i < 3 && i < n_log; i++) begin
         chk("R3 write on internal port", log_pcie[i], 0);
         chk("R3 internal write address", log_addr[i], {32'h0, ia0 + 32'(8 * i)});
         chk("R3 data from PCIe read", log_data[i], pat(pa0 + 64'(8 * i)));
      end
      rd(16'h412C, v); chk("R5 transfer end (reverse)", v[0], 1);
   endtask

   task automatic t_bad_count;
      logic [31:0] v;
      launch(64'h1000, 32'h1000, 32'd12, 1'b1);
      repeat (8) @(negedge clk);
      rd(16'h412C, v);
      chk("R6 termination on odd count", v[12], 1);
      chk("R6 no data moved", n_int + n_pcie, 0);
      rd(16'h4000, v); chk("R6 not active", v[16], 0);
      launch(64'h1000, 32'h1000, 32'h0800_0000, 1'b1);
      repeat (8) @(negedge clk);
      rd(16'h412C, v);
      chk("R6 termination on over-range count", v[12], 1);
      chk("R6 no data moved (over-range)", n_int + n_pcie, 0);
   endtask

   task automatic t_w1c_irq;
      logic [31:0] v;
      // termination flag is set from the previous test, enables were written 0
      repeat (2) @(negedge clk);
      chk("R10 flag without enable: irq low", irq, 0);
      wr(16'h412C, 32'h1000_0000);
      repeat (2) @(negedge clk);
      chk("R10 termination with enable: irq high", irq, 1);
      rd(16'h412C, v);
      chk("R9 enable bit kept, flag kept", v & 32'h1000_1000, 32'h1000_1000);
      wr(16'h412C, 32'h1000_1000);
      repeat (2) @(negedge clk);
      rd(16'h412C, v);
      chk("R9 W1C cleared flag, enable stays", v, 32'h1000_0000);
      chk("R10 irq drops after clear", irq, 0);
      wr(16'h412C, 32'h0);
   endtask

   task automatic t_int_err;
      logic [31:0] v;
      logic [31:0] ia0 = 32'h0000_3000;
      ierr_arm = 1; ierr_addr = {32'h0, ia0 + 32'd16};
      launch(64'h0000_0000_5000_0000, ia0, 32'd32, 1'b1);
      idle_wait();
      ierr_arm = 0;
      rd(16'h412C, v);
      chk("R7 internal error flag", v[9], 1);
      chk("R7 no transfer end", v[0], 0);
      rd(16'h4110, v); chk("R7 remaining count after internal error", v, 16);
      chk("R7 two beats written", n_log, 2);
      rd(16'h4128, v); chk("R7 channel enable cleared", v[31], 0);
      wr(16'h412C, 32'h0800_0000);
      repeat (2) @(negedge clk);
      chk("R10 irq on internal error enable", irq, 0);
      wr(16'h412C, 32'h0200_0000);
      repeat (2) @(negedge clk);
      chk("R10 irq on internal error with its enable", irq, 1);
   endtask

   task automatic t_pcie_err;
      logic [31:0] v;
      logic [63:0] pa0 = 64'h0000_0000_6000_0000;
      perr_arm = 1; perr_addr = pa0 + 64'd8;
      launch(pa0, 32'h100, 32'd32, 1'b1);
      idle_wait();
      perr_arm = 0;
      rd(16'h412C, v);
      chk("R7 PCIe error flag", v[11], 1);
      rd(16'h4110, v); chk("R7 remaining count after PCIe error", v, 24);
   endtask

   task automatic t_abort;
      logic [31:0] v, c1, c2, a1;
      int snap;
      launch(64'h0000_0000_7000_0000, 32'h8000, 32'h100, 1'b1);
      repeat (20) @(negedge clk);
      wr(16'h4108, 32'hDEAD_0000);
      wr(16'h4110, 32'h0000_0008);
      wr(16'h4128, 32'h0);
      repeat (4) @(negedge clk);
      snap = n_int + n_pcie;
      rd(16'h4000, v); chk("R8 active cleared on abort", v[16], 0);
      rd(16'h4110, c1);
      chk("R8 count partial", (c1 < 32'h100) && (c1 > 0) && (c1[2:0] == 0), 1);
      rd(16'h4108, a1);
      chk("R11 internal address write ignored", a1 + c1, 32'h8100);
      chk("R11 count write ignored", c1 == 32'h8, 0);
      repeat (20) @(negedge clk);
      chk("R8 no request after abort", n_int + n_pcie, snap);
      rd(16'h4110, c2); chk("R8 count stable after abort", c2, c1);
      rd(16'h412C, v); chk("R8 abort sets no end flag", v[0], 0);
   endtask

   task automatic t_zero;
      logic [31:0] v;
      launch(64'h9000, 32'h9000, 32'd0, 1'b0);
      repeat (6) @(negedge clk);
      rd(16'h412C, v); chk("R12 zero count ends at once", v[0], 1);
      chk("R12 zero count issues no request", n_int + n_pcie, 0);
      rd(16'h4128, v); chk("R12 channel enable cleared", v[31], 0);
   endtask

   task automatic summary;
      if (!done_flag) begin
         done_flag = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_gate();
      t_int_to_pcie();
      t_pcie_to_int();
      t_bad_count();
      t_w1c_irq();
      t_int_err();
      t_pcie_err();
      t_abort();
      t_zero();
      summary();
   end
endmodule